// File: doc/BRIEF.md
# Multi-Format Pixel Expander with Colour Map

This block turns one stored framebuffer word into a display-ready colour: a 24-bit RGB value and an 8-bit alpha. Each pixel arrives with a 3-bit format code taken from its window's attribute entry. The code selects one of these layouts: 8-bit palette index, 16-bit 5-6-5, 16-bit 1-5-5-5 with one alpha bit, 24-bit packed, or 32-bit with an 8-bit alpha. The same pixel also carries a 4-bit window colour-map offset and a gamma-bypass control.

Palette pixels always fetch their colour from a 1024-entry, 32-bit colour map. Direct-colour pixels first widen each packed channel to 8 bits. When gamma is not bypassed, each widened channel is then run through the colour map as a per-channel correction table. Software loads the map through a write port that runs alongside the pixel stream. The result is registered and appears one cycle after the pixel is accepted.

Top module: `pixel_expander`

## Requirements
- R1: Format code 0 (palette) looks up the colour-map entry at address (offset*64 + pixel[7:0]) modulo 1024. The output is RGB = entry[23:0] and alpha = entry[31:24], where an entry is packed {alpha, red, green, blue} from the top byte down. pixel[31:8] has no effect.
- R2: Format code 1 (5-6-5) reads blue from pixel[4:0], green from pixel[10:5] and red from pixel[15:11]. A 5-bit field v widens to {v, v[4:2]} and a 6-bit field w widens to {w, w[5:4]}. Alpha is 0xFF.
- R3: Format code 2 (1-5-5-5) reads blue from pixel[4:0], green from pixel[9:5] and red from pixel[14:10], each widened as in R2. Alpha is 0xFF when pixel[15] is 1 and 0x00 otherwise.
- R4: Format code 4 (24-bit) outputs RGB = pixel[23:0] with alpha 0xFF. pixel[31:24] has no effect.
- R5: Format code 5 (32-bit) outputs RGB = pixel[23:0] with alpha = pixel[31:24].
- R6: For formats 1, 2, 4 and 5 with gamma bypass at 0, each widened channel c is replaced by the matching byte of the map entry at (offset*64 + c) modulo 1024: red from bits 23:16, green from bits 15:8, blue from bits 7:0. Alpha is not mapped. With bypass at 1, the widened values pass straight through.
- R7: The gamma-bypass input has no effect on format code 0.
- R8: Format codes 3, 6 and 7 are unused. Such a pixel outputs RGB 0 and alpha 0 and sets the error flag. The flag stays set until reset.
- R9: When cm_we is high, cm_wdata is written to entry cm_waddr at the clock edge. A pixel accepted in that same cycle that reads the same entry gets the old contents. A pixel accepted one cycle later gets the new contents.
- R10: out_valid is high exactly in the cycle after a pixel is accepted (in_valid and in_ready both high). While no pixel is accepted, out_rgb and out_alpha hold their values.
- R11: During reset, in_ready is low and out_valid, out_rgb, out_alpha and the error flag are 0. After reset, in_ready is high. The colour-map contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Block can take a pixel |
| in_pixel | input | 32 | Stored pixel word |
| in_fmt | input | 3 | Pixel format code |
| in_cmap_ofs | input | 4 | Window colour-map offset (units of 64 entries) |
| in_gamma_bypass | input | 1 | 1 = direct pixels skip the colour map |
| cm_we | input | 1 | Colour-map write enable |
| cm_waddr | input | 10 | Colour-map write address |
| cm_wdata | input | 32 | Colour-map entry {alpha, red, green, blue} |
| out_valid | output | 1 | Output colour valid |
| out_rgb | output | 24 | Red, green, blue from the top byte down |
| out_alpha | output | 8 | Alpha |
| fmt_err | output | 1 | Sticky unused-format flag |

## Verification
The assertions assume that reset is applied before the first pixel and that every input is at a known level whenever in_valid is high. A colour-map lookup is only meaningful once its entry has been written, since the map itself is never cleared. The bench therefore fills all 1024 entries with random words before any lookup. It changes inputs only on falling clock edges. Random pixels are drawn only from the defined format codes. The unused codes come last, so the sticky flag cannot hide errors in the earlier checks.

// File: rtl/pxe_pkg.sv
package pxe_pkg;

    localparam int PIX_W          = 32;
    localparam int CH_W           = 8;
    localparam int IDX_W          = 8;
    localparam int OFS_W          = 4;
    localparam int OFS_SHIFT      = 6;
    localparam int CMAP_DEPTH_DEF = 1024;
    localparam int CMAP_DW        = 4 * CH_W;
    localparam int GAMMA_PORTS    = 3;

    typedef enum logic [2:0] {
        PF_PAL8     = 3'd0,
        PF_RGB565   = 3'd1,
        PF_ARGB1555 = 3'd2,
        PF_UNUSED3  = 3'd3,
        PF_RGB888   = 3'd4,
        PF_ARGB8888 = 3'd5,
        PF_UNUSED6  = 3'd6,
        PF_UNUSED7  = 3'd7
    } pix_fmt_e;

    typedef struct packed {
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgba_t;

    typedef struct packed {
        rgba_t            col;
        logic [IDX_W-1:0] idx;
        logic             indexed;
        logic             bad;
    } unpacked_t;

    function automatic logic [CH_W-1:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [CH_W-1:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

endpackage

// File: rtl/pxe_unpack.sv
module pxe_unpack
    import pxe_pkg::*;
(
    input  logic [PIX_W-1:0] pix,
    input  logic [2:0]       fmt,
    output unpacked_t        u
);

    always_comb begin
        u         = '0;
        u.idx     = pix[IDX_W-1:0];
        case (pix_fmt_e'(fmt))
            PF_PAL8: begin
                u.indexed = 1'b1;
            end
            PF_RGB565: begin
                u.col.r = widen5(pix[15:11]);
                u.col.g = widen6(pix[10:5]);
                u.col.b = widen5(pix[4:0]);
                u.col.a = '1;
            end
            PF_ARGB1555: begin
                u.col.r = widen5(pix[14:10]);
                u.col.g = widen5(pix[9:5]);
                u.col.b = widen5(pix[4:0]);
                u.col.a = {CH_W{pix[15]}};
            end
            PF_RGB888: begin
                u.col.r = pix[23:16];
                u.col.g = pix[15:8];
                u.col.b = pix[7:0];
                u.col.a = '1;
            end
            PF_ARGB8888: begin
                u.col.r = pix[23:16];
                u.col.g = pix[15:8];
                u.col.b = pix[7:0];
                u.col.a = pix[31:24];
            end
            default: begin
                u.bad = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pxe_cmap.sv
module pxe_cmap #(
    parameter int DEPTH = 1024,
    parameter int DW    = 32,
    parameter int NRD   = 3,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]   raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end

endmodule

// File: rtl/pxe_select.sv
module pxe_select
    import pxe_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           acc,
    input  unpacked_t                      u,
    input  logic                           bypass,
    input  logic [GAMMA_PORTS-1:0][DW-1:0] rd,
    output logic                           out_valid,
    output rgba_t                          out_px,
    output logic                           err
);

    rgba_t nxt;
    rgba_t e_r, e_g, e_b;

    assign e_r = rgba_t'(rd[0]);
    assign e_g = rgba_t'(rd[1]);
    assign e_b = rgba_t'(rd[2]);

    always_comb begin
        if (u.bad) begin
            nxt = '0;
        end else if (u.indexed) begin
            nxt = e_r;
        end else if (bypass) begin
            nxt = u.col;
        end else begin
            nxt.a = u.col.a;
            nxt.r = e_r.r;
            nxt.g = e_g.g;
            nxt.b = e_b.b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_px    <= '0;
            err       <= 1'b0;
        end else begin
            out_valid <= acc;
            if (acc) begin
                out_px <= nxt;
                err    <= err | u.bad;
            end
        end
    end

    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !acc |=> (!out_valid && $stable(out_px)));

    assert_unused_black_R8: assert property (@(posedge clk) disable iff (rst)
        (acc && u.bad) |=> (out_px == '0 && err));

    assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: rtl/pixel_expander.sv
module pixel_expander
    import pxe_pkg::*;
#(
    parameter int CMAP_DEPTH = CMAP_DEPTH_DEF,
    localparam int AW        = $clog2(CMAP_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_pixel,
    input  logic [2:0]        in_fmt,
    input  logic [OFS_W-1:0]  in_cmap_ofs,
    input  logic              in_gamma_bypass,
    input  logic              cm_we,
    input  logic [AW-1:0]     cm_waddr,
    input  logic [CMAP_DW-1:0] cm_wdata,
    output logic              out_valid,
    output logic [3*CH_W-1:0] out_rgb,
    output logic [CH_W-1:0]   out_alpha,
    output logic              fmt_err
);

    function automatic logic [AW-1:0] map_addr(input logic [OFS_W-1:0] ofs,
                                               input logic [CH_W-1:0]  v);
        return AW'((32'(ofs) << OFS_SHIFT) + 32'(v));
    endfunction

    unpacked_t                           u;
    logic                                acc;
    logic [GAMMA_PORTS-1:0][AW-1:0]      raddr;
    logic [GAMMA_PORTS-1:0][CMAP_DW-1:0] rdata;
    rgba_t                               px;

    assign in_ready = ~rst;
    assign acc      = in_valid & in_ready;

    pxe_unpack u_unpack (
        .pix (in_pixel),
        .fmt (in_fmt),
        .u   (u)
    );

    assign raddr[0] = map_addr(in_cmap_ofs, u.indexed ? u.idx : u.col.r);
    assign raddr[1] = map_addr(in_cmap_ofs, u.col.g);
    assign raddr[2] = map_addr(in_cmap_ofs, u.col.b);

    pxe_cmap #(
        .DEPTH (CMAP_DEPTH),
        .DW    (CMAP_DW),
        .NRD   (GAMMA_PORTS)
    ) u_cmap (
        .clk   (clk),
        .we    (cm_we),
        .waddr (cm_waddr),
        .wdata (cm_wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    pxe_select #(
        .DW (CMAP_DW)
    ) u_select (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .u         (u),
        .bypass    (in_gamma_bypass),
        .rd        (rdata),
        .out_valid (out_valid),
        .out_px    (px),
        .err       (fmt_err)
    );

    assign out_rgb   = {px.r, px.g, px.b};
    assign out_alpha = px.a;

endmodule

// File: tb/pixel_expander_bench.sv
`timescale 1ns/1ps
module pixel_expander_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_pixel = '0;
    logic [2:0]  in_fmt = '0;
    logic [3:0]  in_cmap_ofs = '0;
    logic        in_gamma_bypass = 1'b0;
    logic        cm_we = 1'b0;
    logic [9:0]  cm_waddr = '0;
    logic [31:0] cm_wdata = '0;
    logic        out_valid;
    logic [23:0] out_rgb;
    logic [7:0]  out_alpha;
    logic        fmt_err;

    always #2.5 clk = ~clk;

    pixel_expander u_pixel_expander (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .in_fmt(in_fmt), .in_cmap_ofs(in_cmap_ofs),
        .in_gamma_bypass(in_gamma_bypass), .cm_we(cm_we), .cm_waddr(cm_waddr),
        .cm_wdata(cm_wdata), .out_valid(out_valid), .out_rgb(out_rgb),
        .out_alpha(out_alpha), .fmt_err(fmt_err)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;
    bit          exp_err = 0;
    logic [31:0] model [1024];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int maddr(logic [3:0] o, logic [7:0] v);
        return (int'(o) * 64 + int'(v)) % 1024;
    endfunction

    function automatic logic [7:0] w5(logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [7:0] w6(logic [5:0] v);
        return {v, v[5:4]};
    endfunction

    function automatic logic [31:0] expect_px(logic [31:0] p, logic [2:0] f,
                                              logic [3:0] o, logic byp);
        logic [7:0] a, r, g, bl;
        case (f)
            3'd0: return model[maddr(o, p[7:0])];
            3'd1: begin a = 8'hFF; r = w5(p[15:11]); g = w6(p[10:5]); bl = w5(p[4:0]); end
            3'd2: begin a = p[15] ? 8'hFF : 8'h00; r = w5(p[14:10]); g = w5(p[9:5]); bl = w5(p[4:0]); end
            3'd4: begin a = 8'hFF; r = p[23:16]; g = p[15:8]; bl = p[7:0]; end
            3'd5: begin a = p[31:24]; r = p[23:16]; g = p[15:8]; bl = p[7:0]; end
            default: return 32'h0;
        endcase
        if (!byp) begin
            r  = model[maddr(o, r)][23:16];
            g  = model[maddr(o, g)][15:8];
            bl = model[maddr(o, bl)][7:0];
        end
        return {a, r, g, bl};
    endfunction

    task automatic send(logic [31:0] p, logic [2:0] f, logic [3:0] o, logic byp,
                        string req, bit we = 0, logic [9:0] wa = '0,
                        logic [31:0] wd = '0);
        logic [31:0] e;
        @(negedge clk);
        in_valid = 1'b1; in_pixel = p; in_fmt = f; in_cmap_ofs = o;
        in_gamma_bypass = byp; cm_we = we; cm_waddr = wa; cm_wdata = wd;
        e = expect_px(p, f, o, byp);
        if (f == 3'd3 || f > 3'd5) exp_err = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        cm_we = 1'b0;
        if (we) model[wa] = wd;
        chk({req, " valid (R10)"}, 32'(out_valid), 32'd1);
        chk({req, " colour"}, {out_alpha, out_rgb}, e);
        chk({req, " flag (R8)"}, 32'(fmt_err), 32'(exp_err));
    endtask

    task automatic idle_check();
        logic [31:0] prev;
        @(negedge clk);
        prev = {out_alpha, out_rgb};
        @(posedge clk);
        #1;
        chk("R10 no-accept valid", 32'(out_valid), 32'd0);
        chk("R10 no-accept hold", {out_alpha, out_rgb}, prev);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] p;
        logic [2:0]  f;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11 reset valid", 32'(out_valid), 32'd0);
        chk("R11 reset colour", {out_alpha, out_rgb}, 32'd0);
        chk("R11 reset flag", 32'(fmt_err), 32'd0);
        chk("R11 reset ready", 32'(in_ready), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 ready after reset", 32'(in_ready), 32'd1);

        // load the whole colour map (R9 write port)
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            cm_we = 1'b1; cm_waddr = 10'(i); cm_wdata = $urandom;
            model[i] = cm_wdata;
        end
        @(negedge clk);
        cm_we = 1'b0;

        // directed corner cases
        send(32'h0000FFFF, 3'd1, 4'd0, 1'b1, "R2 all ones");
        send(32'h00000000, 3'd1, 4'd0, 1'b1, "R2 all zeros");
        send(32'h00008000, 3'd2, 4'd0, 1'b1, "R3 alpha bit only");
        send(32'h00007FFF, 3'd2, 4'd0, 1'b1, "R3 alpha clear");
        send(32'hA5123456, 3'd4, 4'd0, 1'b1, "R4 top byte ignored");
        send(32'h5A123456, 3'd5, 4'd0, 1'b1, "R5 alpha byte");
        send(32'hABCDEF05, 3'd0, 4'd3, 1'b1, "R1 upper bits ignored");
        send(32'h000000FF, 3'd0, 4'd15, 1'b1, "R1 address wrap");
        send(32'h00000042, 3'd0, 4'd7, 1'b0, "R7 bypass low on palette");
        send(32'h00000042, 3'd0, 4'd7, 1'b1, "R7 bypass high on palette");
        send(32'h00FF0080, 3'd4, 4'd9, 1'b0, "R6 gamma with offset");
        idle_check();
        // R9 same-cycle write and read return old, next cycle new
        send(32'h00000005, 3'd0, 4'd2, 1'b1, "R9 read during write", 1'b1, 10'd133, 32'hDEADBEEF);
        send(32'h00000005, 3'd0, 4'd2, 1'b1, "R9 read after write");
        chk("R9 new entry seen", {out_alpha, out_rgb}, 32'hDEADBEEF);

        // constrained random over the defined codes
        for (int k = 0; k < 400; k++) begin
            case ($urandom % 5)
                0: f = 3'd0;
                1: f = 3'd1;
                2: f = 3'd2;
                3: f = 3'd4;
                default: f = 3'd5;
            endcase
            p = $urandom;
            send(p, f, 4'($urandom), 1'($urandom),
                 $sformatf("random fmt %0d R1/R2/R3/R4/R5/R6", f),
                 1'($urandom % 4 == 0), 10'($urandom), $urandom);
            if (k % 37 == 0) idle_check();
        end

        // R8 unused codes, last because the flag is sticky
        send(32'hFFFFFFFF, 3'd3, 4'd1, 1'b1, "R8 code 3");
        send(32'h12345678, 3'd6, 4'd1, 1'b0, "R8 code 6");
        send(32'h0000F00D, 3'd7, 4'd1, 1'b1, "R8 code 7");
        send(32'h00123456, 3'd4, 4'd0, 1'b1, "R8 flag stays after good pixel");
        idle_check();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule